// File: doc/BRIEF.md
# Registered Argmax Finder

This block keeps a small array of unsigned entries and, on every rising clock edge, reports the largest value held in the array and the position of that value. Software or neighbouring logic loads entries one at a time through a write port: an address, a data word and an enable. A combinational search walks the array from the lowest position to the highest and keeps a running best. A register stage then captures that best value and its position.

When several entries share the maximum value, the lowest position is reported. Writes to addresses past the last entry are dropped. A synchronous, active-high reset clears the array and both outputs.

Top module: `argmax_reg`

## Requirements
- R1: While `rst` is high at a rising edge, every entry and both outputs clear to zero, so after reset `max_val`=0 and `max_idx`=0 until a nonzero value is written.
- R2: A rising edge with `wr_en`=1 and `wr_addr` below N (default 10) replaces the entry at that address with `wr_data`.
- R3: A write with `wr_addr` in N..15 changes no entry, so `max_val` and `max_idx` stay as they were.
- R4: `max_val` equals the largest unsigned entry, including after the current maximum is overwritten with a smaller value.
- R5: `max_idx` is the address (0-based, binary) of an entry that holds `max_val`.
- R6: When several entries hold the maximum, `max_idx` is the lowest of their addresses.
- R7: A write at rising edge k first shows in `max_val`/`max_idx` after rising edge k+1. The outputs between edges k and k+1 still reflect the array before the write.
- R8: When no write and no reset occurs, the outputs hold their values.
- R9: `max_idx` never exceeds N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_addr | input | 4 | Entry address; N and above are dropped |
| wr_data | input | 4 | Unsigned value to store |
| max_val | output | 4 | Registered largest entry |
| max_idx | output | 4 | Registered lowest position of the largest entry |

## Verification
The hardest state to reach is a tie in which the lower-addressed copy of the maximum is written after the higher one. Another hard case is a maximum that is overwritten downward, so that a runner-up elsewhere must take over. The stimulus builds these cases on purpose. It places equal values at positions 9, 3 and 0 in that order. It then erases the leader and checks that the outputs fall back to the runner-up. After that, a long run of random writes over the full 4-bit address range mixes valid and dropped addresses. A reference model that updates once per edge tracks the array and is compared on every cycle.

// File: rtl/argmax_reg.sv
module argmax_reg #(
  parameter int N  = 10,
  parameter int W  = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  max_val,
  output logic [AW-1:0] max_idx
);

  logic [W-1:0]  entry [N];
  logic [W-1:0]  best_val;
  logic [AW-1:0] best_idx;

  for (genvar g = 0; g < N; g++) begin : g_entry
    wire hit = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk) begin
      if (rst)      entry[g] <= '0;
      else if (hit) entry[g] <= wr_data;
    end
  end

  always_comb begin
    best_val = entry[0];
    best_idx = '0;
    for (int i = 1; i < N; i++) begin
      if (entry[i] > best_val) begin
        best_val = entry[i];
        best_idx = AW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      max_val <= '0;
      max_idx <= '0;
    end else begin
      max_val <= best_val;
      max_idx <= best_idx;
    end
  end

endmodule

// File: rtl/argmax_reg_chk.sv
module argmax_reg_chk #(
  parameter int N  = 10,
  parameter int W  = 4,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [W-1:0]  wr_data,
  input logic [W-1:0]  max_val,
  input logic [AW-1:0] max_idx
);

  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic [1:0] since_rst;
  logic       was_rst;
  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst)                  since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (max_val == '0 && max_idx == '0));

  assert_idx_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0) |-> (max_idx <= LAST));

  assert_write_seen_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr <= LAST && since_rst != 2'd0) |-> ##2 (max_val >= $past(wr_data, 2)));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && !was_rst && !$past(wr_en, 2))
      |-> ($stable(max_val) && $stable(max_idx)));

endmodule

bind argmax_reg argmax_reg_chk #(.N(N), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .max_val(max_val), .max_idx(max_idx)
);

// File: tb/argmax_reg_bench.sv
module argmax_reg_bench;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [3:0] max_val;
  logic [3:0] max_idx;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  int model [N];
  int exp_val = 0;
  int exp_idx = 0;

  always #5 clk = ~clk;

  argmax_reg u_argmax_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .max_val(max_val), .max_idx(max_idx)
  );

  // reference: outputs at each edge come from the array as it stood before that edge
  always @(posedge clk) begin
    if (rst) begin
      exp_val = 0;
      exp_idx = 0;
      foreach (model[k]) model[k] = 0;
    end else begin
      exp_val = -1;
      for (int k = 0; k < N; k++)
        if (model[k] > exp_val) begin exp_val = model[k]; exp_idx = k; end
      if (wr_en && int'(wr_addr) < N) model[wr_addr] = int'(wr_data);
    end
  end

  task automatic compare();
    checks++;
    if (int'(max_val) != exp_val || int'(max_idx) != exp_idx) begin
      failures++;
      $display("FAIL %s: max=%0d idx=%0d expected max=%0d idx=%0d",
               tag, max_val, max_idx, exp_val, exp_idx);
    end
    checks++;
    if (int'(max_idx) >= N) begin
      failures++;
      $display("FAIL R9: idx=%0d expected below %0d", max_idx, N);
    end
  endtask

  task automatic step(input bit we, input int a, input int d, input string t);
    @(negedge clk);
    compare();
    tag = t;
    wr_en = we;
    wr_addr = 4'(a);
    wr_data = 4'(d);
  endtask

  task automatic expect_now(input int v, input int i, input string t);
    @(negedge clk);
    checks++;
    if (int'(max_val) != v || int'(max_idx) != i) begin
      failures++;
      $display("FAIL %s: max=%0d idx=%0d expected max=%0d idx=%0d", t, max_val, max_idx, v, i);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) step(0, 0, 0, "R1");
    rst = 1'b0;
    repeat (3) step(0, 0, 0, "R8");
    expect_now(0, 0, "R1");
    // R2/R7: single write, visible one edge later
    step(1, 5, 9, "R7");
    step(0, 0, 0, "R7");
    step(0, 0, 0, "R2");
    expect_now(9, 5, "R2");
    // R6: ties resolve to lowest address
    step(1, 9, 9, "R6");
    step(1, 2, 9, "R6");
    step(0, 0, 0, "R6");
    step(0, 0, 0, "R6");
    expect_now(9, 2, "R6");
    step(1, 9, 15, "R5");
    step(1, 3, 15, "R6");
    step(1, 0, 15, "R6");
    step(0, 0, 0, "R6");
    step(0, 0, 0, "R6");
    expect_now(15, 0, "R6");
    // R4: erase leaders, runner-up takes over
    step(1, 0, 1, "R4");
    step(1, 3, 0, "R4");
    step(1, 9, 4, "R4");
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R4");
    expect_now(9, 2, "R4");
    // R3: out-of-range addresses dropped
    rst = 1'b1;
    step(0, 0, 0, "R1");
    rst = 1'b0;
    step(1, 4, 7, "R3");
    step(1, 11, 15, "R3");
    step(1, 15, 15, "R3");
    step(1, 10, 14, "R3");
    step(0, 0, 0, "R3");
    step(0, 0, 0, "R3");
    expect_now(7, 4, "R3");
    // R8: long idle hold
    repeat (5) step(0, 0, 0, "R8");
    expect_now(7, 4, "R8");
    // R4/R5: random traffic over the whole address range
    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 15), "R4");
    repeat (3) step(0, 0, 0, "R5");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule